// File: doc/BRIEF.md
# I2C Page-Buffered Nonvolatile Memory Slave

This block is an I2C target that fronts a byte-addressed nonvolatile array, held here as a register file with a timed programming phase. The I2C lines are sampled by a fast system clock. The block recognises its own 7-bit device address and the direction bit. It keeps an internal byte pointer that moves forward on its own after each data byte, and it serves single reads, sequential reads and pointer-setting dummy writes.

Write data is collected in an 8-byte page buffer, and a per-byte mask records which offsets were received. A STOP after at least one data byte programs the whole page in one operation. Only the received bytes change. A busy interval of a fixed number of clock cycles then begins, and during it the block refuses its device address. A master can therefore poll for the end of the write or simply wait out the interval. Each page has a counter of completed programming operations. One selected counter is shown at an output, so the wear cost of byte-wise writing can be measured. When the shadow-enable input is high, write data goes straight into the array with no busy interval and no wear count.

Top module: `i2c_page_eeprom`

## Requirements
- R1: The device address byte is acknowledged only when its upper 7 bits equal DEV_ADDR (default 0x50) and no write cycle is in progress. Otherwise it is not acknowledged and the rest of the transfer up to the next START is ignored.
- R2: In a write, the first byte after the device address is the memory address. Each data byte after it is stored at the pointer, and the pointer then steps through its low 3 bits only, so it wraps within the 8-byte page.
- R3: At STOP, every received byte of the page is programmed in one operation. Bytes of that page that were not received keep their earlier values.
- R4: A STOP that ends a write with at least one data byte, while shadow_en_i is low, raises busy_o for exactly TW_CYCLES clock cycles.
- R5: While busy_o is high, the device address is not acknowledged. It is acknowledged again once busy_o has fallen.
- R6: A STOP that follows the memory address with no data byte only loads the pointer. It raises no busy interval and changes no wear counter.
- R7: A read returns the byte at the current pointer, and the pointer then advances by one across the whole array, wrapping from the last address to 0. Reading goes on while the master acknowledges and ends at its NACK.
- R8: A write of the memory address followed by a repeated START and a read address makes the read begin at that memory address.
- R9: Each page has a wear counter that increments once per programming operation with busy. wear_cnt_o shows the counter of the page chosen by wear_sel_i (page = address bits 7:3).
- R10: When shadow_en_i is high at STOP, the received bytes are stored but busy_o stays low and the wear counter is unchanged.
- R11: After reset, busy_o is 0, sda_oe_o is 0, every byte reads 0xFF and every wear counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe_o | output | 1 | When 1, the data line is pulled low |
| shadow_en_i | input | 1 | Writes go to the array with no busy interval and no wear count |
| wear_sel_i | input | ADDR_W-3 | Page whose wear counter is shown |
| busy_o | output | 1 | Timed programming cycle in progress |
| wear_cnt_o | output | WEAR_W | Wear counter of the selected page |

## Verification
Two events can land on the same clock: a STOP that ends a write commits the page and starts the busy timer, and the next device-address byte must then be checked against that same busy state. The bench provokes this by re-addressing the slave right after the STOP of each write. It expects a NACK while busy and an ACK once the timer has run out. On every clock, a behavioural model compares the length of each busy interval with TW_CYCLES. The bench also counts busy starts so that pointer-only and shadow writes can be shown to start none.

// File: rtl/eep_pkg.sv
package eep_pkg;
   typedef enum logic [3:0] {
      EP_IDLE,
      EP_DEV,
      EP_DEV_ACK,
      EP_MADDR,
      EP_MADDR_ACK,
      EP_WR,
      EP_WR_ACK,
      EP_RD,
      EP_RD_ACK,
      EP_WAIT
   } eep_state_e;

   localparam int unsigned EEP_BYTE_W = 8;
endpackage

// File: rtl/eep_line_sync.sv
module eep_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic sda_o,
   output logic start_o,
   output logic stop_o
);
   logic [STAGES-1:0] scl_ff, sda_ff;
   logic scl_s, sda_s, scl_p, sda_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_ff <= '1;
         sda_ff <= '1;
         scl_p  <= 1'b1;
         sda_p  <= 1'b1;
      end else begin
         scl_ff <= {scl_ff[STAGES-2:0], scl_i};
         sda_ff <= {sda_ff[STAGES-2:0], sda_i};
         scl_p  <= scl_s;
         sda_p  <= sda_s;
      end
   end

   assign scl_s      = scl_ff[STAGES-1];
   assign sda_s      = sda_ff[STAGES-1];
   assign sda_o      = sda_s;
   assign scl_rise_o = scl_s & ~scl_p;
   assign scl_fall_o = ~scl_s & scl_p;
   assign start_o    = scl_s & scl_p & sda_p & ~sda_s;
   assign stop_o     = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/eep_i2c_engine.sv
module eep_i2c_engine
   import eep_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h50
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_rise_i,
   input  logic       scl_fall_i,
   input  logic       sda_i,
   input  logic       start_i,
   input  logic       stop_i,
   input  logic       busy_i,
   input  logic [7:0] rd_data_i,
   output logic       sda_oe_o,
   output logic       dev_ack_o,
   output logic       ld_addr_o,
   output logic       wr_stb_o,
   output logic       rd_adv_o,
   output logic       stop_o,
   output logic [7:0] byte_o
);
   eep_state_e st;
   logic [7:0] sh, tx;
   logic [3:0] bcnt;
   logic       rw, mnack;

   assign byte_o = sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= EP_IDLE;
         sh        <= '0;
         tx        <= '0;
         bcnt      <= '0;
         rw        <= 1'b0;
         mnack     <= 1'b0;
         sda_oe_o  <= 1'b0;
         dev_ack_o <= 1'b0;
         ld_addr_o <= 1'b0;
         wr_stb_o  <= 1'b0;
         rd_adv_o  <= 1'b0;
         stop_o    <= 1'b0;
      end else begin
         dev_ack_o <= 1'b0;
         ld_addr_o <= 1'b0;
         wr_stb_o  <= 1'b0;
         rd_adv_o  <= 1'b0;
         stop_o    <= 1'b0;
         if (start_i) begin
            st       <= EP_DEV;
            bcnt     <= '0;
            sda_oe_o <= 1'b0;
         end else if (stop_i) begin
            st       <= EP_IDLE;
            sda_oe_o <= 1'b0;
            stop_o   <= 1'b1;
         end else begin
            case (st)
               EP_DEV, EP_MADDR, EP_WR: begin
                  if (scl_rise_i) begin
                     sh   <= {sh[6:0], sda_i};
                     bcnt <= bcnt + 4'd1;
                  end else if (scl_fall_i && bcnt == 4'd8) begin
                     bcnt <= '0;
                     if (st == EP_DEV) begin
                        if (sh[7:1] == DEV_ADDR && !busy_i) begin
                           sda_oe_o  <= 1'b1;
                           rw        <= sh[0];
                           dev_ack_o <= 1'b1;
                           st        <= EP_DEV_ACK;
                        end else begin
                           st <= EP_WAIT;
                        end
                     end else if (st == EP_MADDR) begin
                        sda_oe_o  <= 1'b1;
                        ld_addr_o <= 1'b1;
                        st        <= EP_MADDR_ACK;
                     end else begin
                        sda_oe_o <= 1'b1;
                        wr_stb_o <= 1'b1;
                        st       <= EP_WR_ACK;
                     end
                  end
               end
               EP_DEV_ACK: begin
                  if (scl_fall_i) begin
                     if (rw) begin
                        tx       <= rd_data_i;
                        sda_oe_o <= ~rd_data_i[7];
                        bcnt     <= '0;
                        st       <= EP_RD;
                     end else begin
                        sda_oe_o <= 1'b0;
                        st       <= EP_MADDR;
                     end
                  end
               end
               EP_MADDR_ACK, EP_WR_ACK: begin
                  if (scl_fall_i) begin
                     sda_oe_o <= 1'b0;
                     st       <= EP_WR;
                  end
               end
               EP_RD: begin
                  if (scl_rise_i) begin
                     bcnt <= bcnt + 4'd1;
                  end else if (scl_fall_i) begin
                     if (bcnt == 4'd8) begin
                        sda_oe_o <= 1'b0;
                        rd_adv_o <= 1'b1;
                        bcnt     <= '0;
                        st       <= EP_RD_ACK;
                     end else begin
                        tx       <= {tx[6:0], 1'b0};
                        sda_oe_o <= ~tx[6];
                     end
                  end
               end
               EP_RD_ACK: begin
                  if (scl_rise_i) begin
                     mnack <= sda_i;
                  end else if (scl_fall_i) begin
                     if (mnack) begin
                        st <= EP_WAIT;
                     end else begin
                        tx       <= rd_data_i;
                        sda_oe_o <= ~rd_data_i[7];
                        st       <= EP_RD;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/eep_page_store.sv
module eep_page_store #(
   parameter int ADDR_W     = 8,
   parameter int PAGE_BYTES = 8,
   parameter int TW_CYCLES  = 1500,
   parameter int WEAR_W     = 16,
   localparam int OFF_W     = $clog2(PAGE_BYTES),
   localparam int PG_W      = ADDR_W - OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_addr_i,
   input  logic              wr_stb_i,
   input  logic [7:0]        byte_i,
   input  logic              rd_adv_i,
   input  logic              stop_i,
   input  logic              shadow_en_i,
   input  logic [PG_W-1:0]   wear_sel_i,
   output logic [7:0]        rd_data_o,
   output logic              busy_o,
   output logic [WEAR_W-1:0] wear_cnt_o
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int PAGES = 1 << PG_W;
   localparam int TW_W  = $clog2(TW_CYCLES + 1);

   logic [7:0]            mem  [DEPTH];
   logic [7:0]            pbuf [PAGE_BYTES];
   logic [PAGE_BYTES-1:0] pmask;
   logic [PG_W-1:0]       pg;
   logic                  pend;
   logic [ADDR_W-1:0]     ptr;
   logic [TW_W-1:0]       tw_cnt;
   logic                  commit, commit_hw;
   logic [WEAR_W-1:0]     wear_arr [PAGES];

   assign commit    = stop_i && pend;
   assign commit_hw = commit && !shadow_en_i;
   assign rd_data_o = mem[ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
         for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= '0;
         pmask  <= '0;
         pg     <= '0;
         pend   <= 1'b0;
         ptr    <= '0;
         busy_o <= 1'b0;
         tw_cnt <= '0;
      end else begin
         if (busy_o) begin
            if (tw_cnt == '0) busy_o <= 1'b0;
            else              tw_cnt <= tw_cnt - TW_W'(1);
         end
         if (ld_addr_i) begin
            ptr   <= byte_i[ADDR_W-1:0];
            pmask <= '0;
            pend  <= 1'b0;
         end
         if (wr_stb_i) begin
            pbuf[ptr[OFF_W-1:0]]  <= byte_i;
            pmask[ptr[OFF_W-1:0]] <= 1'b1;
            pend                  <= 1'b1;
            pg                    <= ptr[ADDR_W-1:OFF_W];
            ptr <= {ptr[ADDR_W-1:OFF_W], ptr[OFF_W-1:0] + OFF_W'(1)};
         end
         if (rd_adv_i) ptr <= ptr + ADDR_W'(1);
         if (commit) begin
            for (int i = 0; i < PAGE_BYTES; i++)
               if (pmask[i]) mem[{pg, OFF_W'(i)}] <= pbuf[i];
            pend  <= 1'b0;
            pmask <= '0;
            if (commit_hw) begin
               busy_o <= 1'b1;
               tw_cnt <= TW_W'(TW_CYCLES - 1);
            end
         end
      end
   end

   for (genvar p = 0; p < PAGES; p++) begin : g_wear
      logic [WEAR_W-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              cnt <= '0;
         else if (commit_hw && pg == PG_W'(p))    cnt <= cnt + WEAR_W'(1);
      end
      assign wear_arr[p] = cnt;
   end

   assign wear_cnt_o = wear_arr[wear_sel_i];
endmodule

// File: rtl/i2c_page_eeprom.sv
module i2c_page_eeprom #(
   parameter logic [6:0] DEV_ADDR    = 7'h50,
   parameter int         ADDR_W      = 8,
   parameter int         PAGE_BYTES  = 8,
   parameter int         TW_CYCLES   = 1500,
   parameter int         WEAR_W      = 16,
   parameter int         SYNC_STAGES = 2,
   localparam int        PG_W        = ADDR_W - $clog2(PAGE_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe_o,
   input  logic              shadow_en_i,
   input  logic [PG_W-1:0]   wear_sel_i,
   output logic              busy_o,
   output logic [WEAR_W-1:0] wear_cnt_o
);
   if (PAGE_BYTES < 2 || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two of at least 2");
   end
   if (ADDR_W > 8 || ADDR_W <= $clog2(PAGE_BYTES)) begin : g_bad_addr
      $error("ADDR_W must exceed the page offset width and fit one address byte");
   end
   if (TW_CYCLES < 1) begin : g_bad_tw
      $error("TW_CYCLES must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic scl_rise_w, scl_fall_w, sda_w, start_w, stop_w;
   logic dev_ack_w, ld_addr_w, wr_stb_w, rd_adv_w, stop_evt;
   logic [7:0] byte_w, rd_data_w;

   eep_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl_i),
      .sda_i      (sda_i),
      .scl_rise_o (scl_rise_w),
      .scl_fall_o (scl_fall_w),
      .sda_o      (sda_w),
      .start_o    (start_w),
      .stop_o     (stop_w)
   );

   eep_i2c_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_rise_i (scl_rise_w),
      .scl_fall_i (scl_fall_w),
      .sda_i      (sda_w),
      .start_i    (start_w),
      .stop_i     (stop_w),
      .busy_i     (busy_o),
      .rd_data_i  (rd_data_w),
      .sda_oe_o   (sda_oe_o),
      .dev_ack_o  (dev_ack_w),
      .ld_addr_o  (ld_addr_w),
      .wr_stb_o   (wr_stb_w),
      .rd_adv_o   (rd_adv_w),
      .stop_o     (stop_evt),
      .byte_o     (byte_w)
   );

   eep_page_store #(
      .ADDR_W     (ADDR_W),
      .PAGE_BYTES (PAGE_BYTES),
      .TW_CYCLES  (TW_CYCLES),
      .WEAR_W     (WEAR_W)
   ) u_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .ld_addr_i   (ld_addr_w),
      .wr_stb_i    (wr_stb_w),
      .byte_i      (byte_w),
      .rd_adv_i    (rd_adv_w),
      .stop_i      (stop_evt),
      .shadow_en_i (shadow_en_i),
      .wear_sel_i  (wear_sel_i),
      .rd_data_o   (rd_data_w),
      .busy_o      (busy_o),
      .wear_cnt_o  (wear_cnt_o)
   );
endmodule

// File: rtl/eep_chk.sv
module eep_chk #(
   parameter int TW_CYCLES = 1500
) (
   input logic clk,
   input logic rst_n,
   input logic busy_o,
   input logic sda_oe_o,
   input logic shadow_en_i,
   input logic stop_evt,
   input logic dev_ack_w,
   input logic scl_fall_w
);
   localparam int RUN_W = $clog2(TW_CYCLES + 2) + 1;
   logic [RUN_W-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      run_q <= '0;
      else if (busy_o) run_q <= run_q + RUN_W'(1);
      else             run_q <= '0;
   end

   // R4
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(stop_evt && !shadow_en_i));

   // R4
   busy_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> (run_q == RUN_W'(TW_CYCLES)));

   // R5
   no_ack_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dev_ack_w |-> !busy_o);

   // R10
   shadow_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_evt && shadow_en_i && !busy_o) |=> !busy_o);

   // R1
   drive_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe_o) |-> $past(scl_fall_w));
endmodule

bind i2c_page_eeprom eep_chk #(.TW_CYCLES(TW_CYCLES)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .busy_o      (busy_o),
   .sda_oe_o    (sda_oe_o),
   .shadow_en_i (shadow_en_i),
   .stop_evt    (stop_evt),
   .dev_ack_w   (dev_ack_w),
   .scl_fall_w  (scl_fall_w)
);

// File: tb/i2c_page_eeprom_tb.sv
module i2c_page_eeprom_tb;
   localparam int         TW  = 1500;
   localparam int         Q   = 8;
   localparam logic [6:0] DEV = 7'h50;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl = 1'b1;
   logic        sda_m = 1'b1;
   logic        shadow = 1'b0;
   logic [4:0]  wsel = '0;
   wire         sda_oe;
   wire         busy;
   wire  [15:0] wcnt;
   wire         sda_line = sda_m & ~sda_oe;

   always #10 clk = ~clk;

   i2c_page_eeprom #(.TW_CYCLES(TW)) u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_i       (scl),
      .sda_i       (sda_line),
      .sda_oe_o    (sda_oe),
      .shadow_en_i (shadow),
      .wear_sel_i  (wsel),
      .busy_o      (busy),
      .wear_cnt_o  (wcnt)
   );

   int checks = 0;
   int errors = 0;
   logic [7:0] exp_mem [256];
   int exp_ptr = 0;
   int busy_rises = 0;
   int run = 0;
   logic prev_busy = 1'b0;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // per-clock model of the busy interval (R4)
   always @(posedge clk) begin
      if (rst_n) begin
         if (busy && !prev_busy) busy_rises++;
         if (busy) run++;
         else if (run != 0) begin
            chk("R4 busy width", run, TW);
            run = 0;
         end
         prev_busy = busy;
      end
   end

   task automatic half();
      repeat (Q) @(negedge clk);
   endtask

   task automatic i2c_start();
      sda_m = 1'b1; scl = 1'b1; half();
      sda_m = 1'b0; half();
      scl = 1'b0; half();
   endtask

   task automatic i2c_restart();
      sda_m = 1'b1; half();
      scl = 1'b1; half();
      sda_m = 1'b0; half();
      scl = 1'b0; half();
   endtask

   task automatic i2c_stop();
      sda_m = 1'b0; half();
      scl = 1'b1; half();
      sda_m = 1'b1; half();
   endtask

   task automatic bit_xfer(input logic b, output logic r);
      sda_m = b; half();
      scl = 1'b1; half();
      r = sda_line; half();
      scl = 1'b0; half();
   endtask

   task automatic send_byte(input logic [7:0] d, output logic ack);
      logic r;
      for (int k = 7; k >= 0; k--) bit_xfer(d[k], r);
      bit_xfer(1'b1, r);
      ack = ~r;
   endtask

   task automatic recv_byte(input logic give_ack, output logic [7:0] d);
      logic r;
      for (int k = 7; k >= 0; k--) begin
         bit_xfer(1'b1, r);
         d[k] = r;
      end
      bit_xfer(~give_ack, r);
   endtask

   task automatic wr(input string tag, input int addr, input int n, input int base);
      logic ack;
      int pgb;
      i2c_start();
      send_byte({DEV, 1'b0}, ack);
      chk({tag, " dev ack"}, ack, 1);
      send_byte(addr[7:0], ack);
      chk({tag, " addr ack"}, ack, 1);
      for (int k = 0; k < n; k++) begin
         send_byte(8'((base + k) & 255), ack);
         chk({tag, " data ack"}, ack, 1);
      end
      i2c_stop();
      pgb = addr & 8'hF8;
      for (int k = 0; k < n; k++)
         exp_mem[pgb + ((addr + k) & 7)] = 8'((base + k) & 255);
      if (n == 0) exp_ptr = addr;
      else        exp_ptr = pgb + ((addr + n) & 7);
   endtask

   task automatic rd_check(input string tag, input logic set_ptr, input int addr, input int n);
      logic ack;
      logic [7:0] d;
      i2c_start();
      if (set_ptr) begin
         send_byte({DEV, 1'b0}, ack);
         chk({tag, " dev ack"}, ack, 1);
         send_byte(addr[7:0], ack);
         chk({tag, " addr ack"}, ack, 1);
         i2c_restart();
         exp_ptr = addr;
      end
      send_byte({DEV, 1'b1}, ack);
      chk({tag, " read ack"}, ack, 1);
      for (int k = 0; k < n; k++) begin
         recv_byte(k < n - 1, d);
         chk(tag, d, exp_mem[exp_ptr]);
         exp_ptr = (exp_ptr + 1) % 256;
      end
      i2c_stop();
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (busy) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   initial begin
      logic ack;
      int r0;
      for (int i = 0; i < 256; i++) exp_mem[i] = 8'hFF;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R11 reset state
      chk("R11 busy after reset", busy, 0);
      chk("R11 sda released", sda_oe, 0);
      chk("R11 wear zero", wcnt, 0);
      rd_check("R7 R11 erased current read", 1'b0, 0, 1);

      // R1 foreign address
      i2c_start();
      send_byte({DEV + 7'd1, 1'b0}, ack);
      chk("R1 foreign address NACK", ack, 0);
      i2c_stop();

      // R2 R4 full page, then R5 polling
      wr("R2 full page", 'h10, 8, 'hA0);
      chk("R4 busy after STOP", busy, 1);
      i2c_start();
      send_byte({DEV, 1'b0}, ack);
      chk("R5 NACK while busy", ack, 0);
      i2c_stop();
      wait_idle();
      i2c_start();
      send_byte({DEV, 1'b0}, ack);
      chk("R5 ACK after busy", ack, 1);
      i2c_stop();
      wsel = 5'd2;
      @(negedge clk);
      chk("R9 one full page write", wcnt, 1);
      rd_check("R8 R3 dummy write readback", 1'b1, 'h10, 8);

      // R3 R9 byte-at-a-time on page 3
      for (int k = 0; k < 8; k++) begin
         wr("R3 single byte", 'h18 + ((k + 3) & 7), 1, 'h50 + k);
         wait_idle();
         if (k == 0) rd_check("R3 untouched bytes", 1'b1, 'h18, 8);
      end
      rd_check("R3 page after singles", 1'b1, 'h18, 8);
      wsel = 5'd3;
      @(negedge clk);
      chk("R9 eight single writes", wcnt, 8);

      // R2 wrap within page
      wr("R2 wrap", 'h26, 3, 'h11);
      wait_idle();
      rd_check("R2 wrap readback", 1'b1, 'h20, 9);

      // R6 pointer-only write
      r0 = busy_rises;
      wr("R6 pointer only", 'h12, 0, 0);
      repeat (40) @(negedge clk);
      chk("R6 no busy", busy_rises, r0);
      wsel = 5'd2;
      @(negedge clk);
      chk("R6 no wear", wcnt, 1);
      rd_check("R6 R7 current read", 1'b0, 0, 1);

      // R7 sequential and wrap
      rd_check("R7 sequential across page", 1'b1, 'h1E, 4);
      rd_check("R7 current after burst", 1'b0, 0, 1);
      rd_check("R7 array wrap", 1'b1, 'hFF, 2);

      // R10 shadow writes
      shadow = 1'b1;
      r0 = busy_rises;
      wr("R10 shadow write", 'h30, 2, 'hC0);
      repeat (40) @(negedge clk);
      chk("R10 no busy", busy_rises, r0);
      wsel = 5'd6;
      @(negedge clk);
      chk("R10 no wear", wcnt, 0);
      shadow = 1'b0;
      rd_check("R10 shadow readback", 1'b1, 'h30, 2);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule